// File: doc/BRIEF.md
# Transmit Slot Sequencer with Antenna-Switch Handshake

This block runs one transmit slot at a time. When the processor raises transmit-enable, the sequencer sends a one-cycle slot marker to the up-converter. It then waits for the up-converter to answer by changing the level of a handshake line. The antenna switch is turned on only once that answer arrives. The switch control is active low, so driving it low turns the switch on, and it is held low for the rest of the slot. When transmit-enable drops, the block sends a second marker to close the slot, releases the switch, and goes back to idle.

Sample words reach the up-converter through a valid/ready stream gate that is open only while the slot is active. Outside the slot the sink side never sees valid, and the source side never sees ready, so a source that offers data early simply stalls. Inside the slot, back-pressure passes straight through: ready on the source side follows ready on the sink side, and the data goes through unchanged. If the handshake does not arrive within a set number of cycles, an error flag is raised and the switch stays off for that attempt.

Top module: `tx_slot_seq`

## Requirements
- R1: After reset the switch control `ant_sw_n_o` is high, `slot_mark_o` and `hs_err_o` are low, and neither `s_ready_o` nor `m_valid_o` is asserted.
- R2: A high `tx_en_i` seen while idle produces exactly one single-cycle start pulse on `slot_mark_o`.
- R3: After the start marker, `ant_sw_n_o` stays high until a level change on `hs_toggle_i` is seen through a two-flop synchroniser. A rise and a fall both count as a change.
- R4: Once the handshake change is accepted, `ant_sw_n_o` goes low and stays low as long as `tx_en_i` stays high.
- R5: When `tx_en_i` drops in the active slot, a single-cycle end pulse appears on `slot_mark_o`, and `ant_sw_n_o` returns high exactly one cycle after that pulse.
- R6: If no handshake change arrives within `TIMEOUT_CYC` cycles of waiting, `hs_err_o` goes high. The switch then stays high even if a later change arrives. The block returns to idle without an end marker when `tx_en_i` drops, and `hs_err_o` clears at the next start marker.
- R7: If `tx_en_i` drops while the block is still waiting for the handshake and no timeout has occurred, an end marker is produced and the switch is never turned on.
- R8: Outside the active slot, `s_ready_o` and `m_valid_o` are low. Inside it, `s_ready_o` equals `m_ready_i`, `m_valid_o` equals `s_valid_i`, and `m_data_o` equals `s_data_i`.
- R9: Changes on `hs_toggle_i` while idle or while the slot is active have no effect on the markers or on the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit-enable from the processor |
| hs_toggle_i | input | 1 | Asynchronous handshake line from the up-converter |
| slot_mark_o | output | 1 | Single-cycle pulse at slot start and at slot end |
| ant_sw_n_o | output | 1 | Antenna switch control, low means on |
| hs_err_o | output | 1 | Handshake timeout flag |
| s_valid_i | input | 1 | Source sample valid |
| s_ready_o | output | 1 | Source sample ready |
| s_data_i | input | DATA_W | Source sample word |
| m_valid_o | output | 1 | Sink sample valid |
| m_ready_i | input | 1 | Sink sample ready |
| m_data_o | output | DATA_W | Sink sample word |

## Verification
The bench offers samples before the slot opens. A gate that leaked them would show a data transfer that the scoreboard never expected. It toggles the handshake while idle and again while active, and a design that reacts to those toggles would produce an extra marker or a switch edge. It also checks that the switch releases exactly one cycle after the end marker; releasing too early or too late fails that timing check. Further cases cover a handshake that never arrives and transmit-enable dropping during the wait. A design that turned the switch on after a timeout, or that left out the end marker when the wait is cancelled, would produce a switch-on event or a missing marker.

// File: rtl/tx_slot_pkg.sv
package tx_slot_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_START  = 3'd1,
    SQ_WAIT   = 3'd2,
    SQ_ACTIVE = 3'd3,
    SQ_END    = 3'd4
  } sq_state_e;
endpackage

// File: rtl/hs_toggle_sync.sv
module hs_toggle_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic change_o
);
  localparam int LAST = SYNC_STAGES;

  // stages [0..SYNC_STAGES-1] synchronise, stage LAST holds previous level
  logic [LAST:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[LAST-1:0], async_i};
  end

  assign change_o = sh_q[LAST] ^ sh_q[LAST-1];
endmodule

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q != LIM)   cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIM);
endmodule

// File: rtl/slot_fsm.sv
module slot_fsm
  import tx_slot_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tx_en_i,
  input  logic      hs_change_i,
  input  logic      expired_i,
  output logic      wait_o,
  output logic      open_o,
  output logic      mark_o,
  output logic      sw_n_o,
  output logic      err_o,
  output sq_state_e state_o
);
  sq_state_e state_q, state_d;
  logic      err_q;
  logic      sw_n_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SQ_IDLE:   if (tx_en_i) state_d = SQ_START;
      SQ_START:  state_d = SQ_WAIT;
      SQ_WAIT: begin
        if (!tx_en_i)                              state_d = err_q ? SQ_IDLE : SQ_END;
        else if (!err_q && !expired_i && hs_change_i) state_d = SQ_ACTIVE;
      end
      SQ_ACTIVE: if (!tx_en_i) state_d = SQ_END;
      SQ_END:    state_d = SQ_IDLE;
      default:   state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      err_q   <= 1'b0;
      sw_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      sw_n_q  <= (state_q != SQ_ACTIVE);
      if (state_q == SQ_IDLE && tx_en_i)               err_q <= 1'b0;
      else if (state_q == SQ_WAIT && expired_i && tx_en_i) err_q <= 1'b1;
    end
  end

  assign wait_o  = (state_q == SQ_WAIT);
  assign open_o  = (state_q == SQ_ACTIVE);
  assign mark_o  = (state_q == SQ_START) || (state_q == SQ_END);
  assign sw_n_o  = sw_n_q;
  assign err_o   = err_q;
  assign state_o = state_q;
endmodule

// File: rtl/stream_gate.sv
module stream_gate #(
  parameter int DATA_W = 16
) (
  input  logic              open_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [DATA_W-1:0] m_data_o
);
  assign m_valid_o = open_i & s_valid_i;
  assign s_ready_o = open_i & m_ready_i;
  assign m_data_o  = s_data_i;
endmodule

// File: rtl/tx_slot_seq.sv
module tx_slot_seq
  import tx_slot_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int TIMEOUT_CYC = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              hs_toggle_i,
  output logic              slot_mark_o,
  output logic              ant_sw_n_o,
  output logic              hs_err_o,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [DATA_W-1:0] s_data_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [DATA_W-1:0] m_data_o
);
  logic      hs_change;
  logic      waiting;
  logic      expired;
  logic      slot_open;
  sq_state_e state;

  hs_toggle_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(hs_toggle_i), .change_o(hs_change)
  );

  slot_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(waiting), .expired_o(expired)
  );

  slot_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .hs_change_i(hs_change),
    .expired_i(expired), .wait_o(waiting), .open_o(slot_open), .mark_o(slot_mark_o),
    .sw_n_o(ant_sw_n_o), .err_o(hs_err_o), .state_o(state)
  );

  stream_gate #(.DATA_W(DATA_W)) u_gate (
    .open_i(slot_open), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
    .s_data_i(s_data_i), .m_valid_o(m_valid_o), .m_ready_i(m_ready_i),
    .m_data_o(m_data_o)
  );
endmodule

// File: rtl/tx_slot_seq_chk.sv
module tx_slot_seq_chk
  import tx_slot_pkg::*;
(
  input logic      clk_i,
  input logic      rst_ni,
  input sq_state_e state,
  input logic      slot_mark_o,
  input logic      ant_sw_n_o,
  input logic      hs_err_o,
  input logic      s_ready_o,
  input logic      m_valid_o,
  input logic      m_ready_i
);
  a_r2_mark_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_mark_o |=> !slot_mark_o);

  a_r5_release_after_mark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_mark_o && !ant_sw_n_o) |=> ant_sw_n_o);

  a_r6_err_keeps_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_err_o |-> ant_sw_n_o);

  a_r3_off_while_waiting: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == SQ_WAIT) |=> ant_sw_n_o);

  a_r8_closed_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != SQ_ACTIVE) |-> (!s_ready_o && !m_valid_o));

  a_r8_ready_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> m_ready_i);
endmodule

bind tx_slot_seq tx_slot_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state(state), .slot_mark_o(slot_mark_o),
  .ant_sw_n_o(ant_sw_n_o), .hs_err_o(hs_err_o), .s_ready_o(s_ready_o),
  .m_valid_o(m_valid_o), .m_ready_i(m_ready_i)
);

// File: tb/tx_slot_seq_tb_top.sv
module tx_slot_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int TMO = 16;
  localparam int EV_MARK = 1, EV_SWON = 2, EV_SWOFF = 3, EV_ERR = 4, EV_DATA = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_en = 1'b0, hs_tgl = 1'b0;
  logic mark, sw_n, err;
  logic s_valid = 1'b0, s_ready, m_valid, m_ready = 1'b1;
  logic [DW-1:0] s_data = '0, m_data;

  int checks = 0, fails = 0, cyc = 0, last_mark = -10;
  int expq[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_slot_seq #(.DATA_W(DW), .TIMEOUT_CYC(TMO)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tx_en_i(tx_en), .hs_toggle_i(hs_tgl),
    .slot_mark_o(mark), .ant_sw_n_o(sw_n), .hs_err_o(err),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data),
    .m_valid_o(m_valid), .m_ready_i(m_ready), .m_data_o(m_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic see(input int code, input string req);
    int e;
    if (expq.size() == 0) chk(1'b0, req, code, -1);
    else begin
      e = expq.pop_front();
      chk(e == code, req, code, e);
    end
  endtask

  // monitor: samples 2 time units after each falling edge
  initial begin
    logic prev_sw = 1'b1, prev_err = 1'b0;
    forever begin
      @(negedge clk); #2;
      cyc++;
      if (rst_n) begin
        if (mark) begin see(EV_MARK, "R2/R5 marker"); last_mark = cyc; end
        if (prev_sw && !sw_n) see(EV_SWON, "R4 switch on");
        if (!prev_sw && sw_n) begin
          see(EV_SWOFF, "R5 switch off");
          chk(cyc == last_mark + 1, "R5 release one cycle after end marker", cyc - last_mark, 1);
        end
        if (err && !prev_err) see(EV_ERR, "R6 timeout flag");
        if (m_valid && m_ready) see(EV_DATA + int'(m_data), "R8 data");
      end
      prev_sw = sw_n; prev_err = err;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_word(input logic [DW-1:0] d);
    s_valid = 1'b1; s_data = d; #1;
    while (!s_ready) begin @(negedge clk); #1; end
    expq.push_back(EV_DATA + int'(d));
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    #1;
    chk(sw_n == 1'b1, "R1 switch reset high", sw_n, 1);
    chk(mark == 1'b0 && err == 1'b0, "R1 marker/err reset low", {mark, err}, 0);
    chk(!s_ready && !m_valid, "R1 gate closed", {s_ready, m_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // samples offered and handshake toggled before any slot (R8, R9)
    s_valid = 1'b1; s_data = 16'h0BAD;
    hs_tgl = ~hs_tgl;
    idle(6); #1;
    chk(!s_ready && !m_valid, "R8 no transfer outside slot", {s_ready, m_valid}, 0);
    chk(sw_n == 1'b1, "R9 idle toggle ignored", sw_n, 1);
    @(negedge clk); s_valid = 1'b0;

    // normal slot
    expq.push_back(EV_MARK);
    tx_en = 1'b1;
    idle(5); #1;
    chk(sw_n == 1'b1, "R3 switch off before handshake", sw_n, 1);
    @(negedge clk);
    expq.push_back(EV_SWON);
    hs_tgl = ~hs_tgl;
    idle(6); #1;
    chk(sw_n == 1'b0, "R4 switch on after handshake", sw_n, 0);
    @(negedge clk);
    hs_tgl = ~hs_tgl;   // R9 toggle while active
    idle(4); #1;
    chk(sw_n == 1'b0, "R9 active toggle ignored", sw_n, 0);
    @(negedge clk);
    send_word(16'h1234);
    send_word(16'hA5A5);
    m_ready = 1'b0; s_valid = 1'b1; s_data = 16'h7777; #1;
    chk(s_ready == 1'b0, "R8 back-pressure passes", s_ready, 0);
    @(negedge clk);
    m_ready = 1'b1;
    send_word(16'h7777);
    expq.push_back(EV_MARK);
    expq.push_back(EV_SWOFF);
    tx_en = 1'b0;
    idle(6);

    // timeout slot (R6)
    expq.push_back(EV_MARK);
    expq.push_back(EV_ERR);
    tx_en = 1'b1;
    idle(TMO + 8); #1;
    chk(err == 1'b1, "R6 error raised", err, 1);
    chk(sw_n == 1'b1, "R6 switch held off", sw_n, 1);
    @(negedge clk);
    hs_tgl = ~hs_tgl;
    idle(6); #1;
    chk(sw_n == 1'b1, "R6 late handshake ignored", sw_n, 1);
    @(negedge clk);
    tx_en = 1'b0;
    idle(5);

    // cancelled wait (R7), error clears at next start (R6)
    expq.push_back(EV_MARK);
    tx_en = 1'b1;
    idle(2); #1;
    chk(err == 1'b0, "R6 error cleared at new slot", err, 0);
    @(negedge clk);
    expq.push_back(EV_MARK);
    tx_en = 1'b0;
    idle(8); #1;
    chk(sw_n == 1'b1, "R7 switch never on", sw_n, 1);
    chk(expq.size() == 0, "R2 all expected events seen", expq.size(), 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule